// File: doc/BRIEF.md
# Exception Entry Sequencer

This block decides how a processor core enters a general or a debug exception, and it captures the state that the handler later needs. The pipeline presents one cycle of request with a cause code, and for a general exception an optional faulting address. The block also sees the PC of the excepting instruction, the current processor status word and the current interrupt level. On the next clock edge it updates its saved-state registers. It emits a new status word with a write enable for the status register's owner, a one-cycle take strobe and a 2-bit vector selector.

For a general exception, the exception-mode and user-mode bits of the incoming status word pick the vector: double, user or kernel. The return PC goes to a dedicated double-exception register when one is configured, and to the first-level return register otherwise. A debug exception is accepted only below a configured debug level. It saves its cause, the PC and the old status word into the registers for that level, and it raises the interrupt level to the debug level.

The status word layout is fixed. Bits [3:0] hold the interrupt level, bit 4 is the exception-mode flag and bit 5 is the user-mode flag.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset, every saved register (epc1, depc, exc_cause, exc_vaddr, dbg_cause, dbg_epc, dbg_eps) reads zero, and take_exc and ps_we are low.
- R2: An accepted general request with status bit 4 clear loads pc_in into epc1 on the next edge. It selects vector code 1 (user) when status bit 5 is set, and vector code 0 (kernel) when bit 5 is clear.
- R3: An accepted general request with status bit 4 already set selects vector code 2 (double). With HAS_DEPC=1 it loads pc_in into depc and leaves epc1 unchanged. With HAS_DEPC=0 it loads pc_in into epc1.
- R4: An accepted general request loads gen_cause into exc_cause. It drives ps_wdata equal to ps_in with bit 4 set, and all other bits are preserved.
- R5: exc_vaddr takes gen_addr only on an accepted general request with gen_addr_vld high. Otherwise it keeps its value.
- R6: A debug request is accepted only when cur_intlevel is strictly less than DBG_LEVEL. A rejected debug request alone gives no strobe and changes no register.
- R7: An accepted debug request loads dbg_cause, saves pc_in into dbg_epc and saves ps_in into dbg_eps. It selects vector code 3 (debug). It drives ps_wdata equal to ps_in with bits [3:0] replaced by DBG_LEVEL and bit 4 set.
- R8: When a general request and an accepted debug request arrive in the same cycle, only the debug entry happens. epc1, depc, exc_cause and exc_vaddr keep their values.
- R9: take_exc and ps_we pulse high for exactly the one cycle that follows an accepted request, with exc_vec valid in that cycle. Without an accepted request both stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_req | input | 1 | General exception request (one cycle) |
| gen_cause | input | CAUSE_W | General exception cause code |
| gen_addr_vld | input | 1 | The request carries a faulting address |
| gen_addr | input | XLEN | Faulting virtual address |
| dbg_req | input | 1 | Debug exception request (one cycle) |
| dbg_cause_in | input | CAUSE_W | Debug cause code |
| pc_in | input | XLEN | PC of the excepting instruction |
| ps_in | input | XLEN | Current processor status word |
| cur_intlevel | input | IL_W | Current interrupt level |
| take_exc | output | 1 | Exception taken strobe |
| exc_vec | output | 2 | Vector: 0 kernel, 1 user, 2 double, 3 debug |
| ps_we | output | 1 | Status word write enable |
| ps_wdata | output | XLEN | New status word |
| epc1 | output | XLEN | First-level return PC |
| depc | output | XLEN | Double-exception return PC (zero when not configured) |
| exc_cause | output | CAUSE_W | General exception cause |
| exc_vaddr | output | XLEN | Faulting virtual address |
| dbg_cause | output | CAUSE_W | Debug cause |
| dbg_epc | output | XLEN | Return PC for the debug level |
| dbg_eps | output | XLEN | Saved status word for the debug level |

## Verification
The saved registers are visible at the ports. A wrong capture, such as the PC going to the wrong return register, a stale cause or a dropped faulting address, shows up in the cycle right after the request edge. A wrong priority or gating decision shows up in the same cycle as a wrong vector code or strobe, or as a general-side register that changed when it should have held. An error in the status word construction appears on ps_wdata during the strobe cycle.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int PS_IL_LSB = 0;
    localparam int PS_IL_W   = 4;
    localparam int PS_EXCM   = 4;
    localparam int PS_UM     = 5;

    typedef enum logic [1:0] {
        VEC_KERNEL = 2'd0,
        VEC_USER   = 2'd1,
        VEC_DOUBLE = 2'd2,
        VEC_DEBUG  = 2'd3
    } vec_e;

    function automatic logic [31:0] ps_with_excm(input logic [31:0] ps);
        logic [31:0] r;
        r = ps;
        r[PS_EXCM] = 1'b1;
        return r;
    endfunction

    function automatic logic [31:0] ps_debug_entry(input logic [31:0] ps,
                                                   input logic [PS_IL_W-1:0] lvl);
        logic [31:0] r;
        r = ps;
        r[PS_IL_LSB +: PS_IL_W] = lvl;
        r[PS_EXCM] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/exc_entry_decide.sv
module exc_entry_decide
    import exc_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int IL_W      = 4,
    parameter int DBG_LEVEL = 3
) (
    input  logic            gen_req,
    input  logic            dbg_req,
    input  logic [XLEN-1:0] ps_in,
    input  logic [IL_W-1:0] cur_intlevel,
    output logic            gen_take,
    output logic            dbg_take,
    output logic            is_double,
    output vec_e            vec,
    output logic [XLEN-1:0] new_ps
);
    localparam logic [IL_W-1:0] DBG_LVL = IL_W'(DBG_LEVEL);

    always_comb begin
        dbg_take  = dbg_req && (cur_intlevel < DBG_LVL);
        gen_take  = gen_req && !dbg_take;
        is_double = ps_in[PS_EXCM];
        if (dbg_take) begin
            vec    = VEC_DEBUG;
            new_ps = ps_debug_entry(ps_in, PS_IL_W'(DBG_LEVEL));
        end else begin
            if (is_double)
                vec = VEC_DOUBLE;
            else if (ps_in[PS_UM])
                vec = VEC_USER;
            else
                vec = VEC_KERNEL;
            new_ps = ps_with_excm(ps_in);
        end
    end
endmodule

// File: rtl/exc_gen_regs.sv
module exc_gen_regs #(
    parameter int XLEN     = 32,
    parameter int CAUSE_W  = 6,
    parameter bit HAS_DEPC = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               take,
    input  logic               is_double,
    input  logic [CAUSE_W-1:0] cause,
    input  logic               addr_vld,
    input  logic [XLEN-1:0]    addr,
    input  logic [XLEN-1:0]    pc,
    output logic [XLEN-1:0]    epc1,
    output logic [XLEN-1:0]    depc,
    output logic [CAUSE_W-1:0] cause_q,
    output logic [XLEN-1:0]    vaddr_q
);
    logic to_depc;

    generate
        if (HAS_DEPC) begin : g_depc
            logic [XLEN-1:0] depc_q;
            assign to_depc = is_double;
            always_ff @(posedge clk) begin
                if (rst)
                    depc_q <= '0;
                else if (take && to_depc)
                    depc_q <= pc;
            end
            assign depc = depc_q;
        end else begin : g_no_depc
            assign to_depc = 1'b0;
            assign depc    = '0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            epc1    <= '0;
            cause_q <= '0;
            vaddr_q <= '0;
        end else if (take) begin
            if (!to_depc)
                epc1 <= pc;
            cause_q <= cause;
            if (addr_vld)
                vaddr_q <= addr;
        end
    end
endmodule

// File: rtl/exc_dbg_regs.sv
module exc_dbg_regs #(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               take,
    input  logic [CAUSE_W-1:0] cause,
    input  logic [XLEN-1:0]    pc,
    input  logic [XLEN-1:0]    ps_old,
    output logic [CAUSE_W-1:0] cause_q,
    output logic [XLEN-1:0]    epc_q,
    output logic [XLEN-1:0]    eps_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= '0;
            epc_q   <= '0;
            eps_q   <= '0;
        end else if (take) begin
            cause_q <= cause;
            epc_q   <= pc;
            eps_q   <= ps_old;
        end
    end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int CAUSE_W   = 6,
    parameter int IL_W      = 4,
    parameter int DBG_LEVEL = 3,
    parameter bit HAS_DEPC  = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               gen_req,
    input  logic [CAUSE_W-1:0] gen_cause,
    input  logic               gen_addr_vld,
    input  logic [XLEN-1:0]    gen_addr,
    input  logic               dbg_req,
    input  logic [CAUSE_W-1:0] dbg_cause_in,
    input  logic [XLEN-1:0]    pc_in,
    input  logic [XLEN-1:0]    ps_in,
    input  logic [IL_W-1:0]    cur_intlevel,
    output logic               take_exc,
    output logic [1:0]         exc_vec,
    output logic               ps_we,
    output logic [XLEN-1:0]    ps_wdata,
    output logic [XLEN-1:0]    epc1,
    output logic [XLEN-1:0]    depc,
    output logic [CAUSE_W-1:0] exc_cause,
    output logic [XLEN-1:0]    exc_vaddr,
    output logic [CAUSE_W-1:0] dbg_cause,
    output logic [XLEN-1:0]    dbg_epc,
    output logic [XLEN-1:0]    dbg_eps
);
    logic            gen_take, dbg_take, is_double;
    vec_e            vec_d;
    logic [XLEN-1:0] new_ps;

    exc_entry_decide #(.XLEN(XLEN), .IL_W(IL_W), .DBG_LEVEL(DBG_LEVEL)) u_dec (
        .gen_req(gen_req), .dbg_req(dbg_req), .ps_in(ps_in),
        .cur_intlevel(cur_intlevel), .gen_take(gen_take), .dbg_take(dbg_take),
        .is_double(is_double), .vec(vec_d), .new_ps(new_ps)
    );

    exc_gen_regs #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .HAS_DEPC(HAS_DEPC)) u_gen (
        .clk(clk), .rst(rst), .take(gen_take), .is_double(is_double),
        .cause(gen_cause), .addr_vld(gen_addr_vld), .addr(gen_addr), .pc(pc_in),
        .epc1(epc1), .depc(depc), .cause_q(exc_cause), .vaddr_q(exc_vaddr)
    );

    exc_dbg_regs #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_dbg (
        .clk(clk), .rst(rst), .take(dbg_take), .cause(dbg_cause_in),
        .pc(pc_in), .ps_old(ps_in), .cause_q(dbg_cause), .epc_q(dbg_epc),
        .eps_q(dbg_eps)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            take_exc <= 1'b0;
            ps_we    <= 1'b0;
            exc_vec  <= 2'd0;
            ps_wdata <= '0;
        end else begin
            take_exc <= gen_take || dbg_take;
            ps_we    <= gen_take || dbg_take;
            if (gen_take || dbg_take) begin
                exc_vec  <= vec_d;
                ps_wdata <= new_ps;
            end
        end
    end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
    parameter int XLEN      = 32,
    parameter int CAUSE_W   = 6,
    parameter int IL_W      = 4,
    parameter int DBG_LEVEL = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               gen_req,
    input logic               gen_addr_vld,
    input logic               dbg_req,
    input logic [XLEN-1:0]    pc_in,
    input logic [XLEN-1:0]    ps_in,
    input logic [IL_W-1:0]    cur_intlevel,
    input logic               take_exc,
    input logic [1:0]         exc_vec,
    input logic               ps_we,
    input logic [XLEN-1:0]    ps_wdata,
    input logic [XLEN-1:0]    epc1,
    input logic [XLEN-1:0]    exc_vaddr,
    input logic [XLEN-1:0]    dbg_eps
);
    logic dbg_ok;
    assign dbg_ok = dbg_req && (cur_intlevel < IL_W'(DBG_LEVEL));

    // R9
    strobe_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        (gen_req || dbg_ok) |=> (take_exc && ps_we));

    // R9
    no_spurious_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !(gen_req || dbg_ok) |=> !take_exc);

    // R2
    epc1_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (gen_req && !dbg_ok && !ps_in[4]) |=> (epc1 == $past(pc_in)));

    // R6
    dbg_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (dbg_req && !dbg_ok && !gen_req) |=> (!take_exc && $stable(dbg_eps)));

    // R7
    dbg_ps_chk: assert property (@(posedge clk) disable iff (rst)
        (take_exc && exc_vec == 2'd3) |->
            (ps_wdata[3:0] == 4'(DBG_LEVEL) && ps_wdata[4]));

    // R4
    gen_excm_chk: assert property (@(posedge clk) disable iff (rst)
        (take_exc && exc_vec != 2'd3) |-> ps_wdata[4]);

    // R5
    vaddr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(gen_req && gen_addr_vld) |=> $stable(exc_vaddr));
endmodule

bind exc_entry_seq exc_entry_chk #(
    .XLEN(XLEN), .CAUSE_W(CAUSE_W), .IL_W(IL_W), .DBG_LEVEL(DBG_LEVEL)
) u_chk (
    .clk(clk), .rst(rst), .gen_req(gen_req), .gen_addr_vld(gen_addr_vld),
    .dbg_req(dbg_req), .pc_in(pc_in), .ps_in(ps_in), .cur_intlevel(cur_intlevel),
    .take_exc(take_exc), .exc_vec(exc_vec), .ps_we(ps_we), .ps_wdata(ps_wdata),
    .epc1(epc1), .exc_vaddr(exc_vaddr), .dbg_eps(dbg_eps)
);

// File: tb/tb_exc_entry_seq.sv
module tb_exc_entry_seq;
    localparam int XLEN = 32;
    localparam int CW   = 6;
    localparam int ILW  = 4;
    localparam int DBGL = 3;

    logic clk = 1'b0;
    logic rst;
    logic gen_req, gen_addr_vld, dbg_req;
    logic [CW-1:0] gen_cause, dbg_cause_in;
    logic [XLEN-1:0] gen_addr, pc_in, ps_in;
    logic [ILW-1:0] cur_intlevel;
    logic take_exc, ps_we;
    logic [1:0] exc_vec;
    logic [XLEN-1:0] ps_wdata, epc1, depc, exc_vaddr, dbg_epc, dbg_eps;
    logic [CW-1:0] exc_cause, dbg_cause;

    int errors = 0;
    int checks = 0;

    logic [XLEN-1:0] m_epc1, m_depc, m_vaddr, m_depc_dbg, m_eps;
    logic [CW-1:0]   m_cause, m_dcause;

    exc_entry_seq #(.XLEN(XLEN), .CAUSE_W(CW), .IL_W(ILW), .DBG_LEVEL(DBGL),
                    .HAS_DEPC(1'b1)) dut (
        .clk(clk), .rst(rst), .gen_req(gen_req), .gen_cause(gen_cause),
        .gen_addr_vld(gen_addr_vld), .gen_addr(gen_addr), .dbg_req(dbg_req),
        .dbg_cause_in(dbg_cause_in), .pc_in(pc_in), .ps_in(ps_in),
        .cur_intlevel(cur_intlevel), .take_exc(take_exc), .exc_vec(exc_vec),
        .ps_we(ps_we), .ps_wdata(ps_wdata), .epc1(epc1), .depc(depc),
        .exc_cause(exc_cause), .exc_vaddr(exc_vaddr), .dbg_cause(dbg_cause),
        .dbg_epc(dbg_epc), .dbg_eps(dbg_eps)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_gen_vec(input logic [31:0] ps);
        if (ps[4]) return 2'd2;
        return ps[5] ? 2'd1 : 2'd0;
    endfunction

    task automatic apply(input logic g, input logic d, input logic [31:0] ps,
                         input logic [3:0] il, input logic [5:0] gc,
                         input logic [5:0] dc, input logic av,
                         input logic [31:0] a, input logic [31:0] pc);
        logic dtake, gtake;
        logic [31:0] eps;
        logic [1:0]  evec;
        dtake = d && (il < 4'(DBGL));
        gtake = g && !dtake;
        gen_req = g; dbg_req = d; ps_in = ps; cur_intlevel = il;
        gen_cause = gc; dbg_cause_in = dc; gen_addr_vld = av; gen_addr = a;
        pc_in = pc;
        evec = 2'd0;
        eps  = ps;
        if (dtake) begin
            m_dcause = dc; m_depc_dbg = pc; m_eps = ps;
            evec = 2'd3;
            eps = {ps[31:5], 1'b1, 4'(DBGL)};
        end else if (gtake) begin
            if (ps[4]) m_depc = pc; else m_epc1 = pc;
            m_cause = gc;
            if (av) m_vaddr = a;
            evec = exp_gen_vec(ps);
            eps = ps | 32'h10;
        end
        @(posedge clk);
        @(negedge clk);
        gen_req = 1'b0; dbg_req = 1'b0;
        chk("R9 take_exc", {31'd0, take_exc}, {31'd0, dtake || gtake});
        chk("R9 ps_we", {31'd0, ps_we}, {31'd0, dtake || gtake});
        if (dtake || gtake) begin
            chk(dtake ? "R7 vec" : "R2/R3 vec", {30'd0, exc_vec}, {30'd0, evec});
            chk(dtake ? "R7 ps_wdata" : "R4 ps_wdata", ps_wdata, eps);
        end
        chk("R2 epc1", epc1, m_epc1);
        chk("R3 depc", depc, m_depc);
        chk(dtake ? "R8 exc_cause" : "R4 exc_cause", {26'd0, exc_cause}, {26'd0, m_cause});
        chk("R5 exc_vaddr", exc_vaddr, m_vaddr);
        chk(d && !dtake ? "R6 dbg_cause" : "R7 dbg_cause", {26'd0, dbg_cause}, {26'd0, m_dcause});
        chk("R7 dbg_epc", dbg_epc, m_depc_dbg);
        chk("R7 dbg_eps", dbg_eps, m_eps);
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        rst = 1'b1;
        gen_req = 0; dbg_req = 0; gen_addr_vld = 0; gen_addr = 0;
        gen_cause = 0; dbg_cause_in = 0; pc_in = 0; ps_in = 0; cur_intlevel = 0;
        m_epc1 = 0; m_depc = 0; m_vaddr = 0; m_depc_dbg = 0; m_eps = 0;
        m_cause = 0; m_dcause = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 take_exc", {31'd0, take_exc}, 32'd0);
        chk("R1 ps_we", {31'd0, ps_we}, 32'd0);
        chk("R1 epc1", epc1, 0);
        chk("R1 depc", depc, 0);
        chk("R1 exc_vaddr", exc_vaddr, 0);
        chk("R1 dbg_eps", dbg_eps, 0);

        // R2 kernel and user vectors
        apply(1, 0, 32'h0000_0001, 0, 6'd5, 0, 1, 32'hDEAD_0000, 32'h1000_0000);
        apply(1, 0, 32'h0000_0020, 0, 6'd7, 0, 0, 32'h1111_1111, 32'h1000_0004);
        // R3 double exception
        apply(1, 0, 32'h0000_0030, 0, 6'd9, 0, 1, 32'hBEEF_0000, 32'h2000_0000);
        // R6 debug rejected at and above level
        apply(0, 1, 32'h0, 4'(DBGL), 0, 6'd3, 0, 0, 32'h3000_0000);
        apply(0, 1, 32'h0, 4'd15, 0, 6'd3, 0, 0, 32'h3000_0004);
        // R7 debug accepted just below level
        apply(0, 1, 32'hA5A5_0021, 4'(DBGL - 1), 0, 6'd2, 0, 0, 32'h4000_0000);
        // R8 both at once, debug wins
        apply(1, 1, 32'h0000_0000, 0, 6'd33, 6'd1, 1, 32'hCAFE_CAFE, 32'h5000_0000);
        // R6 rejected debug lets the general request through
        apply(1, 1, 32'h0000_0020, 4'd8, 6'd11, 6'd4, 1, 32'h0BAD_F00D, 32'h6000_0000);
        // R9 idle cycle
        apply(0, 0, 32'h0, 0, 0, 0, 1, 32'hFFFF_FFFF, 32'h7000_0000);

        for (int i = 0; i < 300; i++) begin
            logic g, d, av;
            logic [31:0] ps;
            g  = ($urandom % 3) != 0;
            d  = ($urandom % 3) == 0;
            av = $urandom % 2;
            ps = $urandom;
            apply(g, d, ps, 4'($urandom), 6'($urandom), 6'($urandom), av,
                  $urandom, $urandom);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule